// File: doc/BRIEF.md
# PPP HDLC Transmit Framer

This block turns a packet byte stream into an HDLC-like framed byte stream ready to be mapped into a SONET payload. A frame begins with the first byte the source offers and ends with the byte marked `in_last`. The block puts a flag byte (0x7E) in front of each frame and a flag after it, and it fills every unused byte slot between frames with flags. Payload bytes that would look like a flag or an escape are escaped. A complemented frame check sequence follows each frame, either 16 or 32 bits wide.

The output runs at the rate of the line's byte slots. The downstream mapper raises `slot_en` in each cycle that it can take a byte. The framer registers the byte for that slot and shows it on `out_data` with `out_vld` one cycle later. Input is taken through a valid/ready handshake. `in_ready` can only be high in a slot cycle, and it drops while the block sends the second byte of an escape pair or the FCS.

Two options change the output. A self-synchronous 1+x^43 scrambler can be applied to every framed output byte. A transparent mode skips all framing, for cases where another device does the HDLC processing.

Top module: `hdlc_tx_framer`

## Requirements
- R1: A payload or FCS byte equal to 0x7E or 0x7D goes out as 0x7D followed by the byte XOR 0x20. In the slot that carries that second byte, `in_ready` is low, so each escaped payload byte costs the source exactly one stalled slot.
- R2: After reset `out_vld` and `in_ready` are low. With no frame pending, each slot carries 0x7E. No payload byte is taken until at least one flag has gone out since reset or since the end of the previous frame.
- R3: When a second frame is offered directly behind a first one, a single 0x7E separates them. That flag closes the first frame and opens the second.
- R4: With `cfg_fcs32`=0 the FCS is 2 bytes, a CRC with polynomial x^16+x^12+x^5+1 and preset 0xFFFF. With `cfg_fcs32`=1 it is 4 bytes, the standard CRC-32 with preset 0xFFFFFFFF. Both are computed over the unstuffed payload, LSB first. For the payload "123456789" the FCS bytes are 6E 90 (16-bit) and 26 39 F4 CB (32-bit).
- R5: The FCS is the complement of the CRC register. It is sent least significant byte first, right after the last payload byte, and it is escaped by the same rule as payload.
- R6: A byte, and an `out_vld` pulse, appears only in the cycle after an edge at which `slot_en` was high. No input is taken when `slot_en` is low. Gaps in `slot_en` leave the byte sequence unchanged.
- R7: If the source has no byte ready in a slot in the middle of a frame, that slot carries 0x7D and the next slot carries 0x7E. This aborts the frame.
- R8: With `cfg_scr_en`=1, every framed output byte, flags included, passes through a 1+x^43 self-synchronous scrambler. Each bit, LSB first, is XORed with the scrambled bit sent 43 bit times earlier, and the scrambler history starts at zero after reset.
- R9: With `cfg_transparent`=1, each byte taken at a slot comes out unchanged one cycle later. No flags, escapes, FCS or scrambling are added, and a slot with no input produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source byte present |
| in_ready | output | 1 | Byte is taken at this edge when `in_valid` is also high |
| in_data | input | 8 | Source byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| cfg_fcs32 | input | 1 | 1: 32-bit FCS, 0: 16-bit FCS |
| cfg_scr_en | input | 1 | Turns on the 1+x^43 scrambler |
| cfg_transparent | input | 1 | Turns off all framing |
| slot_en | input | 1 | An output byte slot is available at this edge |
| out_data | output | 8 | Output byte |
| out_vld | output | 1 | `out_data` holds the byte of the previous slot |

## Verification
Each slot's byte is registered once, so it is due on `out_data` one cycle after the edge at which `slot_en` was high. The bench drives inputs on the falling edge and reads `in_ready` just before the next rising edge, which is the edge where the handshake completes. Output is captured on every falling edge that has `out_vld` high. The captured stream is then checked against sequences the bench builds itself from the payload: escaping, FCS, flag positions and abort bytes. In scrambled runs, the bench descrambler is fed the same slots as the design's scrambler. Stall counts come from the same pre-edge samples of `in_ready`, and the check for gaps compares `out_vld` against the registered value of `slot_en`.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int SCR_TAP = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       cfg_fcs32,
  input  logic       cfg_scr_en,
  input  logic       cfg_transparent,
  input  logic       slot_en,
  output logic [7:0] out_data,
  output logic       out_vld
);

  localparam logic [7:0]  FLAG   = 8'h7E;
  localparam logic [7:0]  ESC    = 8'h7D;
  localparam logic [7:0]  ESC_X  = 8'h20;
  localparam logic [31:0] POLY16 = 32'h0000_8408;
  localparam logic [31:0] POLY32 = 32'hEDB8_8320;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_FCS} st_t;

  st_t                st, n_st;
  logic               flag_sent, n_flag;
  logic               esc_pend, n_pend;
  logic [7:0]         esc_byte, n_pbyte;
  logic [31:0]        crc, n_crc, crc_nx;
  logic [31:0]        fcs_sh, n_fcs;
  logic [1:0]         fcs_left, n_left;
  logic [SCR_TAP-1:0] hist, hist_nx;
  logic [7:0]         raw, cand, scr_byte, fin_byte;
  logic               used, emit_cand, take, scr_on;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d,
                                           input logic w32);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ (w32 ? POLY32 : POLY16)) : (r >> 1);
    return r;
  endfunction

  assign in_ready = cfg_transparent ? slot_en :
                    slot_en && !esc_pend && ((st == S_IDLE && flag_sent) || st == S_DATA);
  assign take   = in_valid && in_ready;
  assign scr_on = cfg_scr_en && !cfg_transparent;
  assign crc_nx = crc_step((st == S_IDLE) ? (cfg_fcs32 ? 32'hFFFF_FFFF : 32'h0000_FFFF) : crc,
                           in_data, cfg_fcs32);

  always_comb begin
    raw = FLAG; cand = in_data; used = slot_en; emit_cand = 1'b0;
    n_st = st; n_flag = flag_sent; n_pend = esc_pend; n_pbyte = esc_byte;
    n_crc = crc; n_fcs = fcs_sh; n_left = fcs_left;
    if (cfg_transparent) begin
      raw = in_data; used = take;
      n_st = S_IDLE; n_flag = 1'b0; n_pend = 1'b0;
    end else if (slot_en) begin
      if (esc_pend) begin
        raw = esc_byte; n_pend = 1'b0;
      end else begin
        case (st)
          S_IDLE, S_DATA: begin
            if (take) begin
              emit_cand = 1'b1; n_crc = crc_nx;
              if (in_last) begin
                n_st = S_FCS; n_fcs = ~crc_nx; n_left = cfg_fcs32 ? 2'd3 : 2'd1;
              end else n_st = S_DATA;
            end else if (st == S_IDLE) begin
              raw = FLAG; n_flag = 1'b1;
            end else begin
              raw = ESC; n_st = S_IDLE; n_flag = 1'b0;
            end
          end
          default: begin
            cand = fcs_sh[7:0]; emit_cand = 1'b1;
            n_fcs = fcs_sh >> 8; n_left = fcs_left - 2'd1;
            if (fcs_left == 2'd0) begin n_st = S_IDLE; n_flag = 1'b0; end
          end
        endcase
        if (emit_cand) begin
          if (cand == FLAG || cand == ESC) begin
            raw = ESC; n_pend = 1'b1; n_pbyte = cand ^ ESC_X;
          end else raw = cand;
        end
      end
    end
  end

  always_comb begin
    hist_nx = hist;
    for (int i = 0; i < 8; i++) begin
      scr_byte[i] = raw[i] ^ hist_nx[SCR_TAP-1];
      hist_nx = {hist_nx[SCR_TAP-2:0], scr_byte[i]};
    end
    fin_byte = scr_on ? scr_byte : raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; flag_sent <= 1'b0; esc_pend <= 1'b0; esc_byte <= '0;
      crc <= '0; fcs_sh <= '0; fcs_left <= '0; hist <= '0;
      out_data <= '0; out_vld <= 1'b0;
    end else begin
      st <= n_st; flag_sent <= n_flag; esc_pend <= n_pend; esc_byte <= n_pbyte;
      crc <= n_crc; fcs_sh <= n_fcs; fcs_left <= n_left;
      if (used && scr_on) hist <= hist_nx;
      out_vld <= used;
      if (used) out_data <= fin_byte;
    end
  end

  AST_ESC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent && take && (in_data == FLAG || in_data == ESC)) |=> !in_ready); // R1

  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent && !cfg_scr_en && slot_en && st == S_IDLE && !esc_pend && !take)
      |=> (out_vld && out_data == FLAG)); // R2

  AST_FCS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FCS && !cfg_fcs32) |-> (fcs_left <= 2'd1)); // R4

  AST_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !out_vld); // R6

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_transparent && !cfg_scr_en && slot_en && st == S_DATA && !esc_pend && !in_valid)
      |=> (out_vld && out_data == ESC)); // R7

  AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_transparent && slot_en && in_valid) |=> (out_vld && out_data == $past(in_data))); // R9

endmodule

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0, out_data;
  logic cfg_fcs32 = 1'b0, cfg_scr_en = 1'b0, cfg_transparent = 1'b0;
  logic slot_en = 1'b1, out_vld;

  hdlc_tx_framer i_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .cfg_fcs32(cfg_fcs32),
    .cfg_scr_en(cfg_scr_en), .cfg_transparent(cfg_transparent),
    .slot_en(slot_en), .out_data(out_data), .out_vld(out_vld));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] tx_b [0:31];
  logic [7:0] exp_b [0:63];
  int exp_n;
  logic [7:0] cap [0:255];
  logic [7:0] view [0:255];
  int ncap = 0, rp = 0, last_flags = 0, stalls = 0, gap_err = 0;
  logic gap_mode = 1'b0, scr_d = 1'b0, tr_d = 1'b0, slot_d = 1'b0;
  logic [42:0] dh = '0;

  always @(posedge clk) begin scr_d <= cfg_scr_en; tr_d <= cfg_transparent; slot_d <= slot_en; end
  always @(negedge clk) slot_en <= gap_mode ? ~slot_en : 1'b1;

  always @(negedge clk) if (rst_n && out_vld) begin
    logic [7:0] v;
    v = out_data;
    if (!slot_d) gap_err++;
    if (scr_d && !tr_d)
      for (int i = 0; i < 8; i++) begin
        v[i] = out_data[i] ^ dh[42];
        dh = {dh[41:0], out_data[i]};
      end
    if (ncap < 256) begin cap[ncap] = out_data; view[ncap] = v; ncap++; end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d, input bit w32);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ (w32 ? 32'hEDB88320 : 32'h00008408);
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic push_st(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      exp_b[exp_n] = 8'h7D; exp_b[exp_n+1] = b ^ 8'h20; exp_n += 2;
    end else begin exp_b[exp_n] = b; exp_n++; end
  endtask

  task automatic build(input int n, input bit w32);
    logic [31:0] c;
    c = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    exp_n = 0;
    for (int i = 0; i < n; i++) begin c = ref_crc(c, tx_b[i], w32); push_st(tx_b[i]); end
    c = ~c;
    for (int k = 0; k < (w32 ? 4 : 2); k++) push_st(c[8*k +: 8]);
  endtask

  task automatic send(input int n, input bit with_last);
    bit first = 1'b1;
    for (int i = 0; i < n; i++) begin
      bit acc = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_data = tx_b[i]; in_last = with_last && (i == n - 1);
      while (!acc) begin
        #1 acc = in_ready;
        if (!acc && !first && slot_en) stalls++;
        @(posedge clk);
        if (!acc) @(negedge clk);
      end
      first = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_frame(input string req);
    bit ok = 1'b1;
    int a = 0, e = 0;
    last_flags = 0;
    while (rp < ncap && view[rp] == 8'h7E) begin rp++; last_flags++; end
    if (last_flags == 0) ok = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      if (rp >= ncap || view[rp] !== exp_b[i]) begin
        if (ok) begin a = (rp < ncap) ? int'(view[rp]) : -1; e = exp_b[i]; end
        ok = 1'b0;
      end
      rp++;
    end
    if (rp >= ncap || view[rp] !== 8'h7E) begin
      if (ok) begin a = (rp < ncap) ? int'(view[rp]) : -1; e = 8'h7E; end
      ok = 1'b0;
    end
    check(ok, req, a, e);
  endtask

  task automatic wait_idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_digits();
    for (int i = 0; i < 9; i++) tx_b[i] = 8'h31 + 8'(i);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b0 && out_vld == 1'b0, "R2 reset", {in_ready, out_vld}, 0);
    ncap = 0;
    wait_idle(6);
    check(ncap >= 4 && cap[0] == 8'h7E && cap[ncap-1] == 8'h7E, "R2 idle fill", cap[0], 8'h7E);
  endtask

  task automatic t_fcs16();
    cfg_fcs32 = 1'b0; load_digits();
    ncap = 0; rp = 0;
    send(9, 1'b1); wait_idle(8);
    exp_n = 0;
    for (int i = 0; i < 9; i++) begin exp_b[exp_n] = tx_b[i]; exp_n++; end
    exp_b[exp_n] = 8'h6E; exp_b[exp_n+1] = 8'h90; exp_n += 2;
    expect_frame("R4 R5 fcs16 123456789");
  endtask

  task automatic t_fcs32();
    cfg_fcs32 = 1'b1; load_digits();
    ncap = 0; rp = 0;
    send(9, 1'b1); wait_idle(8);
    exp_n = 0;
    for (int i = 0; i < 9; i++) begin exp_b[exp_n] = tx_b[i]; exp_n++; end
    exp_b[exp_n] = 8'h26; exp_b[exp_n+1] = 8'h39; exp_b[exp_n+2] = 8'hF4; exp_b[exp_n+3] = 8'hCB;
    exp_n += 4;
    expect_frame("R4 R5 fcs32 123456789");
    cfg_fcs32 = 1'b0;
  endtask

  task automatic t_stuff();
    tx_b[0] = 8'h7E; tx_b[1] = 8'h7D; tx_b[2] = 8'h41; tx_b[3] = 8'h20;
    ncap = 0; rp = 0; stalls = 0;
    send(4, 1'b1); wait_idle(10);
    check(stalls == 2, "R1 stall count", stalls, 2);
    build(4, 1'b0);
    expect_frame("R1 R5 stuffed frame");
  endtask

  task automatic t_back2back();
    ncap = 0; rp = 0;
    for (int i = 0; i < 3; i++) tx_b[i] = 8'hA0 + 8'(i);
    send(3, 1'b1);
    for (int i = 0; i < 3; i++) tx_b[i] = 8'hB0 + 8'(i);
    send(3, 1'b1);
    wait_idle(10);
    for (int i = 0; i < 3; i++) tx_b[i] = 8'hA0 + 8'(i);
    build(3, 1'b0); expect_frame("R3 first frame");
    for (int i = 0; i < 3; i++) tx_b[i] = 8'hB0 + 8'(i);
    build(3, 1'b0); expect_frame("R3 second frame");
    check(last_flags == 1, "R3 shared flag", last_flags, 1);
  endtask

  task automatic t_gaps();
    load_digits();
    ncap = 0; rp = 0; gap_err = 0; gap_mode = 1'b1;
    send(9, 1'b1); wait_idle(20);
    gap_mode = 1'b0; wait_idle(2);
    build(9, 1'b0); expect_frame("R6 frame under slot gaps");
    check(gap_err == 0, "R6 output only after slot", gap_err, 0);
  endtask

  task automatic t_abort();
    bit ok = 1'b1;
    tx_b[0] = 8'h11; tx_b[1] = 8'h22;
    ncap = 0; rp = 0;
    send(2, 1'b0); wait_idle(6);
    while (rp < ncap && cap[rp] == 8'h7E) rp++;
    if (rp + 3 >= ncap) ok = 1'b0;
    else if (cap[rp] != 8'h11 || cap[rp+1] != 8'h22 || cap[rp+2] != 8'h7D || cap[rp+3] != 8'h7E)
      ok = 1'b0;
    check(ok, "R7 abort sequence", (rp + 2 < ncap) ? int'(cap[rp+2]) : -1, 8'h7D);
  endtask

  task automatic t_scramble();
    bit diff = 1'b0;
    @(negedge clk); cfg_scr_en = 1'b1;
    wait_idle(12);
    for (int i = 0; i < 5; i++) tx_b[i] = 8'h7E - 8'(i);
    ncap = 0; rp = 0;
    send(5, 1'b1); wait_idle(12);
    build(5, 1'b0); expect_frame("R8 descrambled frame");
    for (int i = 0; i < ncap; i++) if (cap[i] != view[i]) diff = 1'b1;
    check(diff, "R8 scrambling applied", diff, 1);
    @(negedge clk); cfg_scr_en = 1'b0;
    wait_idle(4);
  endtask

  task automatic t_transparent();
    bit ok = 1'b1;
    @(negedge clk); cfg_transparent = 1'b1;
    wait_idle(3);
    ncap = 0;
    tx_b[0] = 8'h7E; tx_b[1] = 8'h7D; tx_b[2] = 8'h00;
    send(3, 1'b1); wait_idle(6);
    check(ncap == 3, "R9 byte count", ncap, 3);
    for (int i = 0; i < 3; i++) if (cap[i] != tx_b[i]) ok = 1'b0;
    check(ok, "R9 bytes unchanged", cap[0], tx_b[0]);
    @(negedge clk); cfg_transparent = 1'b0;
    wait_idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fcs16();
    t_fcs32();
    t_stuff();
    t_back2back();
    t_gaps();
    t_abort();
    t_scramble();
    t_transparent();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule